// File: doc/BRIEF.md
# Load/store buffer coherence tracker

This block keeps the bookkeeping for up to eight in-flight memory operations, ordered oldest first. Each slot holds a physical address, whether the operation is a load or a store, an outstanding miss tag, and seven status flags: valid, has-data, failed, done, stalled, cached and invalidated. A pipeline allocates slots at the young end, updates their status, and frees them when an operation retires or is squashed. Slots are reclaimed from the old end.

Three combinational probes look at all live slots in the same cycle. The first decides whether an instruction-cache miss may proceed. The second decides whether evicting an address range would disturb a live operation. This probe walks the slots in age order and applies skip and early-stop rules. The third input, an intervention that throws out a range, marks the affected slots invalidated on the next edge. When a data-cache miss returns, the slots waiting on its tag are released from their stall. Those that already finished are given their line. The block reports this as one-cycle request pulses, together with a pulse that unstalls instruction fetch.

Top module: `lsb_coh_tracker`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready_o` is 1, `alloc_idx_o` is 0, all pulses and both counters are 0, `imiss_ok_o` is 1 and `ev_conflict_o` is 0.
- R2: An allocation writes the slot shown on `alloc_idx_o`. The slot gets valid=1 and stalled equal to `alloc_miss_i`, and all other flags are 0. Its tag is the given tag, or all ones when there is no miss. `rd_flags_o` shows a slot's flags as bit 6 valid, bit 5 has-data, bit 4 failed, bit 3 done, bit 2 stalled, bit 1 cached and bit 0 invalidated. Once eight slots are in use, `alloc_ready_o` is 0 and a request changes nothing.
- R3: A freed slot becomes reusable only once it is the oldest. The old end advances by at most one freed slot per cycle, starting on the edge after the free.
- R4: `imiss_ok_o` is 0 exactly when some valid slot has the same set index as `imiss_addr_i`. The set index is address bits [11:6] by default.
- R5: An intervention over [base, base+size) sets invalidated, on the next edge, in every valid slot that has data and whose address lies in the range. The end of the range is exclusive.
- R6: With `int_wbonly_i` set, only store slots are marked invalidated. Otherwise loads and stores are both marked.
- R7: `ev_conflict_o` is 1 when a slot reached in oldest-to-youngest order has its address in [base, base+size).
- R8: In that walk, once a slot with failed set has been passed, that slot and every younger slot without data are skipped.
- R9: With `ev_tag_en_i` set, the walk ends with no conflict at the first unskipped slot holding `ev_tag_i`. Age order follows allocation across the index wrap.
- R10: A completion with tag T affects every valid slot holding T. It sets the slot's tag to all ones and clears stalled. If done was set, it sets has-data and pulses `fetch_shared_o` for a load or `fetch_excl_o` for a store. Otherwise it clears cached.
- R11: Every completion raises `unstall_o` for exactly the following cycle, whether or not any slot matched.
- R12: A release clears every flag of a valid slot. A squash adds 1 to `squash_cnt_o`. A squash of a slot without data also adds 1 to `squash_empty_cnt_o`. A retire changes neither count, and a release of an empty slot has no effect.
- R13: A status write overwrites done, failed and cached of a valid slot on the next edge and is ignored for an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a new youngest slot |
| alloc_addr_i | input | AW | Physical address of the new operation |
| alloc_store_i | input | 1 | 1 = store, 0 = load |
| alloc_miss_i | input | 1 | New operation waits on a miss |
| alloc_tag_i | input | TW | Miss tag of the new operation |
| alloc_ready_o | output | 1 | A slot is available |
| alloc_idx_o | output | IW | Slot the next allocation uses |
| st_we_i | input | 1 | Status write strobe |
| st_idx_i | input | IW | Slot to update |
| st_done_i | input | 1 | New done flag |
| st_failed_i | input | 1 | New failed flag |
| st_cached_i | input | 1 | New cached flag |
| cpl_valid_i | input | 1 | Data-cache miss completion |
| cpl_tag_i | input | TW | Tag of the completed miss |
| int_valid_i | input | 1 | Intervention strobe |
| int_base_i | input | AW | Intervention range start |
| int_size_i | input | AW | Intervention range length |
| int_wbonly_i | input | 1 | Writeback-only intervention |
| rel_valid_i | input | 1 | Release strobe |
| rel_idx_i | input | IW | Slot to release |
| rel_squash_i | input | 1 | 1 = squash, 0 = retire |
| imiss_addr_i | input | AW | Instruction miss address probe |
| imiss_ok_o | output | 1 | Instruction miss approved |
| ev_base_i | input | AW | Eviction range start |
| ev_size_i | input | AW | Eviction range length |
| ev_tag_en_i | input | 1 | Use the stop tag |
| ev_tag_i | input | TW | Stop tag |
| ev_conflict_o | output | 1 | Eviction would hit a live slot |
| rd_idx_i | input | IW | Slot to inspect |
| rd_flags_o | output | 7 | Flags of the inspected slot |
| rd_tag_o | output | TW | Tag of the inspected slot |
| fetch_shared_o | output | 1 | A completed load takes its line shared |
| fetch_excl_o | output | 1 | A completed store takes its line exclusive |
| unstall_o | output | 1 | Instruction fetch may resume |
| squash_cnt_o | output | CW | Squashes so far |
| squash_empty_cnt_o | output | CW | Squashes of slots without data |

## Verification
A wrong old-end pointer shows at once as a wrong `ev_conflict_o` after a wrap, because the stop tag is then found on the wrong side of an in-range slot. It also shows as `alloc_ready_o` rising one cycle early or late after a free. A lost or misapplied flag is visible on `rd_flags_o` the cycle after the edge that should have written it. It also changes the probes: a missing has-data hides the slot from interventions and from the walk past a failed slot. Wrong completion matching shows within one cycle as a missing or extra fetch pulse.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    // Per-slot status; the packed order is the order seen on rd_flags_o.
    typedef struct packed {
        logic valid;
        logic has_data;
        logic failed;
        logic done;
        logic stalled;
        logic cached;
        logic inval;
    } ent_flags_t;

endpackage

// File: rtl/lsb_range_match.sv
module lsb_range_match #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32
) (
    input  logic [N-1:0][AW-1:0] addr_i,
    input  logic [AW-1:0]        base_i,
    input  logic [AW-1:0]        size_i,
    output logic [N-1:0]         hit_o
);

    logic [AW:0] lim;

    // one extra bit so a range ending at the top of the space does not wrap
    assign lim = {1'b0, base_i} + {1'b0, size_i};

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = ({1'b0, addr_i[g]} >= {1'b0, base_i}) &&
                          ({1'b0, addr_i[g]} <  lim);
    end

endmodule

// File: rtl/lsb_set_probe.sv
module lsb_set_probe #(
    parameter int unsigned N  = 8,
    parameter int unsigned SW = 6
) (
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0][SW-1:0] set_i,
    input  logic [SW-1:0]        probe_i,
    output logic                 ok_o
);

    logic [N-1:0] clash;

    for (genvar g = 0; g < N; g++) begin : g_set
        assign clash[g] = valid_i[g] && (set_i[g] == probe_i);
    end

    assign ok_o = ~|clash;

endmodule

// File: rtl/lsb_age_walk.sv
module lsb_age_walk #(
    parameter int unsigned N  = 8,
    parameter int unsigned TW = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [IW-1:0]        head_i,
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0]         data_i,
    input  logic [N-1:0]         failed_i,
    input  logic [N-1:0]         hit_i,
    input  logic [N-1:0][TW-1:0] tag_i,
    input  logic                 tag_en_i,
    input  logic [TW-1:0]        tag_probe_i,
    output logic                 conflict_o
);

    localparam logic [TW-1:0] TAG_NONE = '1;

    logic [IW-1:0] slot;
    logic          stop;
    logic          skip_empty;

    // Serial priority walk from the oldest slot; the first decisive slot wins.
    always_comb begin
        conflict_o = 1'b0;
        stop       = 1'b0;
        skip_empty = 1'b0;
        slot       = head_i;
        for (int k = 0; k < N; k++) begin
            slot = head_i + IW'(k);
            if (!stop && valid_i[slot]) begin
                if (failed_i[slot]) begin
                    skip_empty = 1'b1;
                end
                if (!(skip_empty && !data_i[slot])) begin
                    if (tag_en_i && (tag_probe_i != TAG_NONE) &&
                        (tag_i[slot] == tag_probe_i)) begin
                        stop = 1'b1;
                    end else if (hit_i[slot]) begin
                        conflict_o = 1'b1;
                        stop       = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lsb_coh_tracker.sv
module lsb_coh_tracker #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned AW     = 32,
    parameter int unsigned TW     = 4,
    parameter int unsigned CW     = 16,
    parameter int unsigned SET_LO = 6,
    parameter int unsigned SET_W  = 6,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned FW    = $bits(lsb_pkg::ent_flags_t)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          alloc_valid_i,
    input  logic [AW-1:0] alloc_addr_i,
    input  logic          alloc_store_i,
    input  logic          alloc_miss_i,
    input  logic [TW-1:0] alloc_tag_i,
    output logic          alloc_ready_o,
    output logic [IW-1:0] alloc_idx_o,
    input  logic          st_we_i,
    input  logic [IW-1:0] st_idx_i,
    input  logic          st_done_i,
    input  logic          st_failed_i,
    input  logic          st_cached_i,
    input  logic          cpl_valid_i,
    input  logic [TW-1:0] cpl_tag_i,
    input  logic          int_valid_i,
    input  logic [AW-1:0] int_base_i,
    input  logic [AW-1:0] int_size_i,
    input  logic          int_wbonly_i,
    input  logic          rel_valid_i,
    input  logic [IW-1:0] rel_idx_i,
    input  logic          rel_squash_i,
    input  logic [AW-1:0] imiss_addr_i,
    output logic          imiss_ok_o,
    input  logic [AW-1:0] ev_base_i,
    input  logic [AW-1:0] ev_size_i,
    input  logic          ev_tag_en_i,
    input  logic [TW-1:0] ev_tag_i,
    output logic          ev_conflict_o,
    input  logic [IW-1:0] rd_idx_i,
    output logic [FW-1:0] rd_flags_o,
    output logic [TW-1:0] rd_tag_o,
    output logic          fetch_shared_o,
    output logic          fetch_excl_o,
    output logic          unstall_o,
    output logic [CW-1:0] squash_cnt_o,
    output logic [CW-1:0] squash_empty_cnt_o
);

    localparam int unsigned   SPW      = IW + 1;
    localparam logic [SPW-1:0] SPAN_FULL = SPW'(DEPTH);
    localparam logic [TW-1:0] TAG_NONE = '1;

    typedef struct packed {
        logic [SPW-1:0]                    span;
        logic [IW-1:0]                     head;
        logic [IW-1:0]                     tail;
        lsb_pkg::ent_flags_t [DEPTH-1:0]   flg;
        logic [DEPTH-1:0]                  store;
        logic [DEPTH-1:0][AW-1:0]          addr;
        logic [DEPTH-1:0][TW-1:0]          tag;
        logic                              fetch_sh;
        logic                              fetch_ex;
        logic                              unstall;
        logic [CW-1:0]                     sq_cnt;
        logic [CW-1:0]                     sq_empty_cnt;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0]            valid_v, data_v, failed_v;
    logic [DEPTH-1:0][SET_W-1:0] set_v;
    logic [DEPTH-1:0]            int_hit, ev_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign valid_v[g]  = s_q.flg[g].valid;
        assign data_v[g]   = s_q.flg[g].has_data;
        assign failed_v[g] = s_q.flg[g].failed;
        assign set_v[g]    = s_q.addr[g][SET_LO +: SET_W];
    end

    lsb_set_probe #(.N(DEPTH), .SW(SET_W)) i_set_probe (
        .valid_i (valid_v),
        .set_i   (set_v),
        .probe_i (imiss_addr_i[SET_LO +: SET_W]),
        .ok_o    (imiss_ok_o)
    );

    lsb_range_match #(.N(DEPTH), .AW(AW)) i_int_range (
        .addr_i (s_q.addr),
        .base_i (int_base_i),
        .size_i (int_size_i),
        .hit_o  (int_hit)
    );

    lsb_range_match #(.N(DEPTH), .AW(AW)) i_ev_range (
        .addr_i (s_q.addr),
        .base_i (ev_base_i),
        .size_i (ev_size_i),
        .hit_o  (ev_hit)
    );

    lsb_age_walk #(.N(DEPTH), .TW(TW)) i_age_walk (
        .head_i      (s_q.head),
        .valid_i     (valid_v),
        .data_i      (data_v),
        .failed_i    (failed_v),
        .hit_i       (ev_hit),
        .tag_i       (s_q.tag),
        .tag_en_i    (ev_tag_en_i),
        .tag_probe_i (ev_tag_i),
        .conflict_o  (ev_conflict_o)
    );

    logic do_alloc;
    logic do_reclaim;

    assign do_alloc   = alloc_valid_i && (s_q.span != SPAN_FULL);
    assign do_reclaim = (s_q.span != '0) && !s_q.flg[s_q.head].valid;

    always_comb begin
        s_d          = s_q;
        s_d.fetch_sh = 1'b0;
        s_d.fetch_ex = 1'b0;
        s_d.unstall  = cpl_valid_i;

        // status overwrite from the pipeline
        if (st_we_i && s_q.flg[st_idx_i].valid) begin
            s_d.flg[st_idx_i].done   = st_done_i;
            s_d.flg[st_idx_i].failed = st_failed_i;
            s_d.flg[st_idx_i].cached = st_cached_i;
        end

        for (int i = 0; i < DEPTH; i++) begin
            // miss return: release waiters, hand the line to finished ones
            if (cpl_valid_i && s_q.flg[i].valid && (cpl_tag_i != TAG_NONE) &&
                (s_q.tag[i] == cpl_tag_i)) begin
                s_d.tag[i]         = TAG_NONE;
                s_d.flg[i].stalled = 1'b0;
                if (s_q.flg[i].done) begin
                    s_d.flg[i].has_data = 1'b1;
                    if (s_q.store[i]) begin
                        s_d.fetch_ex = 1'b1;
                    end else begin
                        s_d.fetch_sh = 1'b1;
                    end
                end else begin
                    s_d.flg[i].cached = 1'b0;
                end
            end
            // line thrown out under a slot that already holds its data
            if (int_valid_i && s_q.flg[i].valid && s_q.flg[i].has_data &&
                int_hit[i] && (!int_wbonly_i || s_q.store[i])) begin
                s_d.flg[i].inval = 1'b1;
            end
        end

        // retire or squash
        if (rel_valid_i && s_q.flg[rel_idx_i].valid) begin
            s_d.flg[rel_idx_i] = '0;
            if (rel_squash_i) begin
                s_d.sq_cnt = s_q.sq_cnt + CW'(1);
                if (!s_q.flg[rel_idx_i].has_data) begin
                    s_d.sq_empty_cnt = s_q.sq_empty_cnt + CW'(1);
                end
            end
        end

        // old end moves past one freed slot per cycle
        if (do_reclaim) begin
            s_d.head = s_q.head + IW'(1);
        end

        if (do_alloc) begin
            s_d.flg[s_q.tail]         = '0;
            s_d.flg[s_q.tail].valid   = 1'b1;
            s_d.flg[s_q.tail].stalled = alloc_miss_i;
            s_d.addr[s_q.tail]        = alloc_addr_i;
            s_d.store[s_q.tail]       = alloc_store_i;
            s_d.tag[s_q.tail]         = alloc_miss_i ? alloc_tag_i : TAG_NONE;
            s_d.tail                  = s_q.tail + IW'(1);
        end

        s_d.span = s_q.span + SPW'(do_alloc) - SPW'(do_reclaim);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_ready_o      = (s_q.span != SPAN_FULL);
    assign alloc_idx_o        = s_q.tail;
    assign rd_flags_o         = s_q.flg[rd_idx_i];
    assign rd_tag_o           = s_q.tag[rd_idx_i];
    assign fetch_shared_o     = s_q.fetch_sh;
    assign fetch_excl_o       = s_q.fetch_ex;
    assign unstall_o          = s_q.unstall;
    assign squash_cnt_o       = s_q.sq_cnt;
    assign squash_empty_cnt_o = s_q.sq_empty_cnt;

endmodule

// File: rtl/lsb_coh_tracker_chk.sv
module lsb_coh_tracker_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 16,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [IW:0]   span,
    input logic          alloc_valid_i,
    input logic          alloc_ready_o,
    input logic [IW-1:0] alloc_idx_o,
    input logic          cpl_valid_i,
    input logic          unstall_o,
    input logic          fetch_shared_o,
    input logic          fetch_excl_o,
    input logic          imiss_ok_o,
    input logic          ev_conflict_o,
    input logic [CW-1:0] squash_cnt_o,
    input logic [CW-1:0] squash_empty_cnt_o
);

    AST_REFUSED_ALLOC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alloc_valid_i && !alloc_ready_o) |=> $stable(alloc_idx_o)); // R2

    AST_EMPTY_APPROVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (span == '0) |-> (imiss_ok_o && !ev_conflict_o)); // R4

    AST_UNSTALL_AFTER_CPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpl_valid_i |=> unstall_o); // R11

    AST_NO_SPURIOUS_UNSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpl_valid_i |=> !unstall_o); // R11

    AST_FETCH_WITH_UNSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_shared_o || fetch_excl_o) |-> unstall_o); // R10

    AST_SQUASH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (squash_cnt_o != $past(squash_cnt_o)) |->
        (squash_cnt_o == $past(squash_cnt_o) + CW'(1))); // R12

    AST_EMPTY_SQUASH_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (squash_empty_cnt_o != $past(squash_empty_cnt_o)) |->
        (squash_cnt_o != $past(squash_cnt_o))); // R12

endmodule

bind lsb_coh_tracker lsb_coh_tracker_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .span               (s_q.span),
    .alloc_valid_i      (alloc_valid_i),
    .alloc_ready_o      (alloc_ready_o),
    .alloc_idx_o        (alloc_idx_o),
    .cpl_valid_i        (cpl_valid_i),
    .unstall_o          (unstall_o),
    .fetch_shared_o     (fetch_shared_o),
    .fetch_excl_o       (fetch_excl_o),
    .imiss_ok_o         (imiss_ok_o),
    .ev_conflict_o      (ev_conflict_o),
    .squash_cnt_o       (squash_cnt_o),
    .squash_empty_cnt_o (squash_empty_cnt_o)
);

// File: tb/test_lsb_coh_tracker.sv
module test_lsb_coh_tracker;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        alloc_valid_i = 0, alloc_store_i = 0, alloc_miss_i = 0;
    logic [31:0] alloc_addr_i = '0;
    logic [3:0]  alloc_tag_i = '0;
    logic        alloc_ready_o;
    logic [2:0]  alloc_idx_o;
    logic        st_we_i = 0, st_done_i = 0, st_failed_i = 0, st_cached_i = 0;
    logic [2:0]  st_idx_i = '0;
    logic        cpl_valid_i = 0;
    logic [3:0]  cpl_tag_i = '0;
    logic        int_valid_i = 0, int_wbonly_i = 0;
    logic [31:0] int_base_i = '0, int_size_i = '0;
    logic        rel_valid_i = 0, rel_squash_i = 0;
    logic [2:0]  rel_idx_i = '0;
    logic [31:0] imiss_addr_i = '0;
    logic        imiss_ok_o;
    logic [31:0] ev_base_i = '0, ev_size_i = '0;
    logic        ev_tag_en_i = 0;
    logic [3:0]  ev_tag_i = '0;
    logic        ev_conflict_o;
    logic [2:0]  rd_idx_i = '0;
    logic [6:0]  rd_flags_o;
    logic [3:0]  rd_tag_o;
    logic        fetch_shared_o, fetch_excl_o, unstall_o;
    logic [15:0] squash_cnt_o, squash_empty_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk_i = ~clk_i;

    lsb_coh_tracker i_lsb_coh_tracker (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic alloc(input logic [31:0] a, input logic st, input logic miss, input logic [3:0] t);
        alloc_valid_i = 1; alloc_addr_i = a; alloc_store_i = st; alloc_miss_i = miss; alloc_tag_i = t;
        cyc();
        alloc_valid_i = 0;
    endtask

    task automatic stat(input int idx, input logic d, input logic f, input logic c);
        st_we_i = 1; st_idx_i = 3'(idx); st_done_i = d; st_failed_i = f; st_cached_i = c;
        cyc();
        st_we_i = 0;
    endtask

    task automatic cpl(input logic [3:0] t);
        cpl_valid_i = 1; cpl_tag_i = t;
        cyc();
        cpl_valid_i = 0;
    endtask

    task automatic intv(input logic [31:0] b, input logic [31:0] s, input logic wb);
        int_valid_i = 1; int_base_i = b; int_size_i = s; int_wbonly_i = wb;
        cyc();
        int_valid_i = 0;
    endtask

    task automatic rel(input int idx, input logic sq);
        rel_valid_i = 1; rel_idx_i = 3'(idx); rel_squash_i = sq;
        cyc();
        rel_valid_i = 0;
    endtask

    task automatic flags(input string req, input int idx, input logic [6:0] exp);
        rd_idx_i = 3'(idx);
        #1;
        check(req, {25'd0, rd_flags_o}, {25'd0, exp});
    endtask

    task automatic ev(input string req, input logic [31:0] b, input logic [31:0] s,
                      input logic te, input logic [3:0] t, input logic exp);
        ev_base_i = b; ev_size_i = s; ev_tag_en_i = te; ev_tag_i = t;
        #1;
        check(req, {31'd0, ev_conflict_o}, {31'd0, exp});
        ev_tag_en_i = 0;
    endtask

    task automatic imiss(input string req, input logic [31:0] a, input logic exp);
        imiss_addr_i = a;
        #1;
        check(req, {31'd0, imiss_ok_o}, {31'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 ready", {31'd0, alloc_ready_o}, 32'd1);
        check("R1 idx", {29'd0, alloc_idx_o}, 32'd0);
        check("R1 pulses", {29'd0, fetch_shared_o, fetch_excl_o, unstall_o}, 32'd0);
        check("R1 counters", {squash_cnt_o, squash_empty_cnt_o}, 32'd0);
        imiss("R1 imiss", 32'h1040, 1'b1);
        ev("R1 ev", 32'h0, 32'hFFFF_FFFF, 1'b0, 4'h0, 1'b0);
    endtask

    task automatic t_alloc_imiss();
        alloc(32'h1040, 1'b0, 1'b1, 4'd1);
        alloc(32'h2000, 1'b1, 1'b1, 4'd2);
        alloc(32'h3000, 1'b0, 1'b0, 4'd9);
        flags("R2 slot0 flags", 0, 7'h44);
        rd_idx_i = 3'd0; #1;
        check("R2 slot0 tag", {28'd0, rd_tag_o}, 32'd1);
        flags("R2 slot2 flags", 2, 7'h40);
        rd_idx_i = 3'd2; #1;
        check("R2 no-miss tag", {28'd0, rd_tag_o}, 32'hF);
        check("R2 idx advance", {29'd0, alloc_idx_o}, 32'd3);
        imiss("R4 same set", 32'h5040, 1'b0);
        imiss("R4 other set", 32'h1080, 1'b1);
        imiss("R4 set zero", 32'h40000, 1'b0);
    endtask

    task automatic t_complete();
        stat(0, 1'b1, 1'b0, 1'b1);
        flags("R13 status", 0, 7'h4E);
        cpl(4'd1);
        flags("R10 done load", 0, 7'h6A);
        rd_idx_i = 3'd0; #1;
        check("R10 tag cleared", {28'd0, rd_tag_o}, 32'hF);
        check("R10 shared pulse", {30'd0, fetch_shared_o, fetch_excl_o}, 32'h2);
        check("R11 unstall", {31'd0, unstall_o}, 32'd1);
        cyc();
        check("R10 pulse ends", {29'd0, fetch_shared_o, fetch_excl_o, unstall_o}, 32'd0);
        stat(1, 1'b0, 1'b0, 1'b1);
        cpl(4'd2);
        flags("R10 not done", 1, 7'h40);
        check("R10 no fetch", {30'd0, fetch_shared_o, fetch_excl_o}, 32'd0);
        alloc(32'h4000, 1'b1, 1'b1, 4'd4);
        stat(3, 1'b1, 1'b0, 1'b0);
        cpl(4'd4);
        flags("R10 done store", 3, 7'h68);
        check("R10 excl pulse", {30'd0, fetch_shared_o, fetch_excl_o}, 32'h1);
        cpl(4'd7);
        check("R11 unmatched unstall", {31'd0, unstall_o}, 32'd1);
        check("R11 unmatched fetch", {30'd0, fetch_shared_o, fetch_excl_o}, 32'd0);
    endtask

    task automatic t_intervene();
        intv(32'h0, 32'h1040, 1'b0);
        flags("R5 end exclusive", 0, 7'h6A);
        intv(32'h1000, 32'h4000, 1'b1);
        flags("R6 store marked", 3, 7'h69);
        flags("R6 load spared", 0, 7'h6A);
        flags("R5 no data spared", 1, 7'h40);
        intv(32'h1040, 32'h40, 1'b0);
        flags("R5 load marked", 0, 7'h6B);
    endtask

    task automatic t_evict();
        ev("R7 in range", 32'h3000, 32'h40, 1'b0, 4'h0, 1'b1);
        ev("R7 out of range", 32'h5000, 32'h1000, 1'b0, 4'h0, 1'b0);
        stat(1, 1'b0, 1'b1, 1'b0);
        ev("R8 younger empty skipped", 32'h3000, 32'h40, 1'b0, 4'h0, 1'b0);
        ev("R8 younger data seen", 32'h4000, 32'h40, 1'b0, 4'h0, 1'b1);
        ev("R8 failed itself skipped", 32'h2000, 32'h40, 1'b0, 4'h0, 1'b0);
        stat(1, 1'b0, 1'b0, 1'b0);
        ev("R8 cleared failed", 32'h3000, 32'h40, 1'b0, 4'h0, 1'b1);
        alloc(32'h6000, 1'b0, 1'b1, 4'd5);
        alloc(32'h7000, 1'b0, 1'b0, 4'd0);
        ev("R9 stop before hit", 32'h7000, 32'h40, 1'b1, 4'd5, 1'b0);
        ev("R9 no tag hit", 32'h7000, 32'h40, 1'b0, 4'd5, 1'b1);
        ev("R9 hit before stop", 32'h3000, 32'h40, 1'b1, 4'd5, 1'b1);
    endtask

    task automatic t_release();
        rel(2, 1'b1);
        check("R12 squash empty", {squash_cnt_o, squash_empty_cnt_o}, 32'h0001_0001);
        flags("R12 cleared", 2, 7'h00);
        rel(0, 1'b0);
        check("R12 retire", {squash_cnt_o, squash_empty_cnt_o}, 32'h0001_0001);
        flags("R12 retired", 0, 7'h00);
        rel(3, 1'b1);
        check("R12 squash data", {squash_cnt_o, squash_empty_cnt_o}, 32'h0002_0001);
        rel(2, 1'b1);
        check("R12 empty slot", {squash_cnt_o, squash_empty_cnt_o}, 32'h0002_0001);
        ev("R12 freed not seen", 32'h3000, 32'h40, 1'b0, 4'h0, 1'b0);
    endtask

    task automatic t_full();
        check("R2 idx before fill", {29'd0, alloc_idx_o}, 32'd6);
        alloc(32'h9000, 1'b0, 1'b1, 4'd6);
        alloc(32'hA000, 1'b0, 1'b0, 4'd0);
        check("R2 wrap idx", {29'd0, alloc_idx_o}, 32'd0);
        alloc(32'h8000, 1'b0, 1'b0, 4'd0);
        check("R3 full", {31'd0, alloc_ready_o}, 32'd0);
        check("R3 full idx", {29'd0, alloc_idx_o}, 32'd1);
        alloc(32'hB000, 1'b1, 1'b1, 4'd3);
        check("R2 refused idx", {29'd0, alloc_idx_o}, 32'd1);
        flags("R2 refused slot", 1, 7'h40);
        ev("R9 wrap stop", 32'h8000, 32'h40, 1'b1, 4'd6, 1'b0);
        ev("R9 wrap hit", 32'h8000, 32'h40, 1'b0, 4'd6, 1'b1);
        rel(1, 1'b0);
        check("R3 not yet free", {31'd0, alloc_ready_o}, 32'd0);
        cyc();
        check("R3 reclaimed", {31'd0, alloc_ready_o}, 32'd1);
        alloc(32'hC000, 1'b0, 1'b0, 4'd0);
        flags("R3 reuse", 1, 7'h40);
        check("R3 next idx", {29'd0, alloc_idx_o}, 32'd2);
        stat(3, 1'b1, 1'b1, 1'b1);
        flags("R13 empty ignored", 3, 7'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_alloc_imiss();
        t_complete();
        t_intervene();
        t_evict();
        t_release();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule